// File: doc/BRIEF.md
# Pipelined Burst Synchronous SRAM

This block is a synchronous static memory of `2**ADDR_W` words. Each word has `LANES` byte lanes of `LANE_W` bits, which by default gives 36-bit words in four 9-bit lanes. On every rising clock edge it samples three chip selects, two address strobes, a burst-advance input, the write controls and the address.

From these inputs it picks one of four actions:

- deselect;
- start a burst at the external address;
- step the burst to its next address;
- stay on the current burst address.

A 2-bit burst counter walks the low two address bits in either linear or interleaved order. Bursts are started by the processor strobe or the controller strobe. The two strobes follow different selection rules.

Read data passes through one output register, so it appears one clock after the address is taken. The data bus drives only while the output enable is low. Writes take their data on the same edge as the address. Writes can be masked per byte lane, and a global write overrides the mask.

Top module: `sbsram_top`

## Requirements
- R1: With `sel_pri_n` high and `stb_ctl_n` low the cycle is a deselect, whatever the other inputs are; the next cycle does not drive data.
- R2: With `stb_proc_n` or `stb_ctl_n` low, and `sel_sec_p` low or `sel_sec_n` high, the cycle is a deselect.
- R3: With all selects active (`sel_pri_n`=0, `sel_sec_p`=1, `sel_sec_n`=0) and `stb_proc_n` low, a burst starts at `addr` as a read, and all write inputs are ignored.
- R4: With all selects active, `stb_proc_n` high and `stb_ctl_n` low, a burst starts at `addr`. It is a write if the decoded write of R6 is active and a read otherwise.
- R5: With both strobes high, or with `sel_pri_n` high, `stb_proc_n` low and `stb_ctl_n` high:
  - `adv_n`=0 moves to the next burst address and `adv_n`=1 keeps the current one;
  - read or write follows R6;
  - the chip selects are ignored.
- R6: Write decode:
  - `gwr_n`=0 writes all lanes.
  - Otherwise, `bwr_n`=1 is a read.
  - Otherwise, lane i (bits `[9i+8:9i]` of the data) is written when `lane_we_n[i]`=0.
  - If no lane enable is low, the cycle is a read.
- R7: A burst start loads `addr[1:0]` as the burst base and clears the count. Each following address takes its low bits from the base and the count. With `intlv`=0 they are `(base+count) mod 4`. With `intlv`=1 they are `base XOR count`. The upper address bits stay fixed for the whole burst.
- R8: Read data of a cycle appears on `dq_o` after the next rising edge. `dq_oe` is high only while `oe_n` is low and the previous cycle was a read. `dq_o` is high-impedance whenever `dq_oe` is low.
- R9: Reset leaves the block deselected. Advance and hold cycles while deselected neither read nor write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| sel_pri_n | input | 1 | Primary chip select, active low |
| sel_sec_p | input | 1 | Secondary chip select, active high |
| sel_sec_n | input | 1 | Secondary chip select, active low |
| stb_proc_n | input | 1 | Processor address strobe, active low |
| stb_ctl_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| gwr_n | input | 1 | Global write, active low |
| bwr_n | input | 1 | Byte-write enable, active low |
| lane_we_n | input | LANES | Per-lane write enables, active low |
| addr | input | ADDR_W | External word address |
| intlv | input | 1 | Burst order: 0 linear, 1 interleaved |
| oe_n | input | 1 | Output enable, active low, asynchronous |
| wdata | input | LANES*LANE_W | Write data |
| dq_o | output | LANES*LANE_W | Read data, high-impedance when not driven |
| dq_oe | output | 1 | High while `dq_o` is driven |

## Verification
A write changes the array on the same edge that samples its controls. A read's data and `dq_oe` become due at the next rising edge. The effect of `oe_n` is immediate.

The bench drives its inputs on the falling edge. A behavioural model is advanced right after each rising edge, and the outputs are compared at the following falling edge. That falling edge is the first point at which the register for the cycle just taken has loaded.

Directed checks state the exact word expected at each step of a burst. Other directed checks require the bus to stay undriven in the cycle after a deselect, a write or a hold while idle.

// File: rtl/sbsram_pkg.sv
package sbsram_pkg;
   typedef enum logic [2:0] {
      OP_DESEL   = 3'd0,
      OP_START_P = 3'd1,
      OP_START_C = 3'd2,
      OP_STEP    = 3'd3,
      OP_HOLD    = 3'd4
   } sram_op_e;

   localparam int BURST_W = 2;

   function automatic logic [BURST_W-1:0] burst_low(input logic [BURST_W-1:0] base,
                                                   input logic [BURST_W-1:0] cnt,
                                                   input logic il);
      return il ? (base ^ cnt) : (base + cnt);
   endfunction
endpackage

// File: rtl/sbsram_ctrl.sv
module sbsram_ctrl
   import sbsram_pkg::*;
#(
   parameter int ADDR_W = 10
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              sel_pri_n,
   input  logic              sel_sec_p,
   input  logic              sel_sec_n,
   input  logic              stb_proc_n,
   input  logic              stb_ctl_n,
   input  logic              adv_n,
   input  logic              intlv,
   input  logic [ADDR_W-1:0] addr,
   output sram_op_e          op,
   output logic              acc_vld,
   output logic [ADDR_W-1:0] acc_addr
);
   localparam int UP_W = ADDR_W - BURST_W;

   generate
      if (ADDR_W <= BURST_W) begin : g_bad_aw
         $error("sbsram_ctrl: ADDR_W must exceed the burst counter width");
      end
   endgenerate

   logic               active_q;
   logic [UP_W-1:0]    up_q;
   logic [BURST_W-1:0] base_q, cnt_q, cnt_d;
   logic               sel_ok;

   assign sel_ok = !sel_pri_n && sel_sec_p && !sel_sec_n;

   always_comb begin
      if (!sel_pri_n && !stb_proc_n) op = sel_ok ? OP_START_P : OP_DESEL;
      else if (!stb_ctl_n)           op = sel_ok ? OP_START_C : OP_DESEL;
      else                           op = adv_n ? OP_HOLD : OP_STEP;
   end

   always_comb begin
      cnt_d    = cnt_q;
      acc_vld  = 1'b0;
      acc_addr = addr;
      unique case (op)
         OP_START_P, OP_START_C: begin
            acc_vld  = 1'b1;
            acc_addr = addr;
         end
         OP_STEP: begin
            cnt_d    = cnt_q + 1'b1;
            acc_vld  = active_q;
            acc_addr = {up_q, burst_low(base_q, cnt_d, intlv)};
         end
         OP_HOLD: begin
            acc_vld  = active_q;
            acc_addr = {up_q, burst_low(base_q, cnt_q, intlv)};
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         active_q <= 1'b0;
         cnt_q    <= '0;
      end else begin
         unique case (op)
            OP_DESEL: active_q <= 1'b0;
            OP_START_P, OP_START_C: begin
               active_q <= 1'b1;
               up_q     <= addr[ADDR_W-1:BURST_W];
               base_q   <= addr[BURST_W-1:0];
               cnt_q    <= '0;
            end
            OP_STEP: if (active_q) cnt_q <= cnt_d;
            default: ;
         endcase
      end
   end

   // R9: reset leaves the burst state deselected
   a_r9_reset_idle: assert property (@(posedge clk) rst |=> !active_q);
   // R1: primary high with controller strobe low deselects
   a_r1_desel: assert property (@(posedge clk) disable iff (rst)
      (sel_pri_n && !stb_ctl_n) |=> !active_q);
   // R7: upper burst address only changes on a burst start
   a_r7_upper_fixed: assert property (@(posedge clk) disable iff (rst)
      !(op == OP_START_P || op == OP_START_C) |=> $stable(up_q));
endmodule

// File: rtl/sbsram_wdec.sv
module sbsram_wdec #(
   parameter int LANES = 4
) (
   input  logic             gwr_n,
   input  logic             bwr_n,
   input  logic [LANES-1:0] lane_we_n,
   output logic [LANES-1:0] lane_wr,
   output logic             any_wr
);
   generate
      if (LANES < 1) begin : g_bad_lanes
         $error("sbsram_wdec: LANES must be at least 1");
      end
      for (genvar g = 0; g < LANES; g++) begin : g_lane
         assign lane_wr[g] = !gwr_n || (!bwr_n && !lane_we_n[g]);
      end
   endgenerate

   assign any_wr = |lane_wr;
endmodule

// File: rtl/sbsram_array.sv
module sbsram_array #(
   parameter int ADDR_W = 10,
   parameter int LANES  = 4,
   parameter int LANE_W = 9
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic [ADDR_W-1:0]       addr,
   input  logic [LANES-1:0]        wr_lane,
   input  logic [LANES*LANE_W-1:0] wdata,
   input  logic                    rd_en,
   output logic [LANES*LANE_W-1:0] rd_q,
   output logic                    rd_vld
);
   localparam int DEPTH = 1 << ADDR_W;

   generate
      if (LANE_W < 1) begin : g_bad_lw
         $error("sbsram_array: LANE_W must be at least 1");
      end
      for (genvar g = 0; g < LANES; g++) begin : g_lane
         logic [LANE_W-1:0] mem [DEPTH];
         logic [LANE_W-1:0] q;
         always_ff @(posedge clk) begin
            if (wr_lane[g]) mem[addr] <= wdata[g*LANE_W +: LANE_W];
            if (rd_en)      q         <= mem[addr];
         end
         assign rd_q[g*LANE_W +: LANE_W] = q;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) rd_vld <= 1'b0;
      else     rd_vld <= rd_en;
   end
endmodule

// File: rtl/sbsram_top.sv
module sbsram_top
   import sbsram_pkg::*;
#(
   parameter int ADDR_W = 10,
   parameter int LANES  = 4,
   parameter int LANE_W = 9
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic                    sel_pri_n,
   input  logic                    sel_sec_p,
   input  logic                    sel_sec_n,
   input  logic                    stb_proc_n,
   input  logic                    stb_ctl_n,
   input  logic                    adv_n,
   input  logic                    gwr_n,
   input  logic                    bwr_n,
   input  logic [LANES-1:0]        lane_we_n,
   input  logic [ADDR_W-1:0]       addr,
   input  logic                    intlv,
   input  logic                    oe_n,
   input  logic [LANES*LANE_W-1:0] wdata,
   output logic [LANES*LANE_W-1:0] dq_o,
   output logic                    dq_oe
);
   localparam int DW = LANES * LANE_W;

   sram_op_e          op;
   logic              acc_vld;
   logic [ADDR_W-1:0] acc_addr;
   logic [LANES-1:0]  lane_wr, wr_go;
   logic              any_wr, wr_cyc, rd_go, rd_vld;
   logic [DW-1:0]     rd_q;

   sbsram_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
      .clk(clk), .rst(rst), .sel_pri_n(sel_pri_n), .sel_sec_p(sel_sec_p),
      .sel_sec_n(sel_sec_n), .stb_proc_n(stb_proc_n), .stb_ctl_n(stb_ctl_n),
      .adv_n(adv_n), .intlv(intlv), .addr(addr), .op(op),
      .acc_vld(acc_vld), .acc_addr(acc_addr)
   );

   sbsram_wdec #(.LANES(LANES)) u_wdec (
      .gwr_n(gwr_n), .bwr_n(bwr_n), .lane_we_n(lane_we_n),
      .lane_wr(lane_wr), .any_wr(any_wr)
   );

   assign wr_cyc = acc_vld && (op != OP_START_P) && any_wr;
   assign wr_go  = lane_wr & {LANES{wr_cyc}};
   assign rd_go  = acc_vld && !wr_cyc;

   sbsram_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
      .clk(clk), .rst(rst), .addr(acc_addr), .wr_lane(wr_go), .wdata(wdata),
      .rd_en(rd_go), .rd_q(rd_q), .rd_vld(rd_vld)
   );

   assign dq_oe = rd_vld && !oe_n;
   assign dq_o  = dq_oe ? rd_q : {DW{1'bz}};

   // R3: a processor-strobe start never writes
   a_r3_proc_no_write: assert property (@(posedge clk) disable iff (rst)
      (op == OP_START_P) |-> (wr_go == '0));
   // R6: global write reaches every lane
   a_r6_global_all: assert property (@(posedge clk) disable iff (rst)
      (!gwr_n && acc_vld && op != OP_START_P) |-> (&wr_go));
   // R8: a read cycle makes data valid one edge later
   a_r8_read_valid: assert property (@(posedge clk) disable iff (rst)
      rd_go |=> rd_vld);
   // R8: a cycle that does not read leaves nothing to drive
   a_r8_noread_quiet: assert property (@(posedge clk) disable iff (rst)
      !rd_go |=> !dq_oe);
endmodule

// File: tb/sim_sbsram_top.sv
`timescale 1ns/1ps
module sim_sbsram_top;
   localparam int AW = 10;
   localparam int DW = 36;

   logic clk = 1'b0;
   logic rst;
   logic sel_pri_n, sel_sec_p, sel_sec_n, stb_proc_n, stb_ctl_n, adv_n;
   logic gwr_n, bwr_n, intlv, oe_n;
   logic [3:0]    lane_we_n;
   logic [AW-1:0] addr;
   logic [DW-1:0] wdata;
   logic [DW-1:0] dq_o;
   logic          dq_oe;

   always #2 clk = ~clk;

   sbsram_top #(.ADDR_W(AW), .LANES(4), .LANE_W(9)) u0 (
      .clk(clk), .rst(rst), .sel_pri_n(sel_pri_n), .sel_sec_p(sel_sec_p),
      .sel_sec_n(sel_sec_n), .stb_proc_n(stb_proc_n), .stb_ctl_n(stb_ctl_n),
      .adv_n(adv_n), .gwr_n(gwr_n), .bwr_n(bwr_n), .lane_we_n(lane_we_n),
      .addr(addr), .intlv(intlv), .oe_n(oe_n), .wdata(wdata),
      .dq_o(dq_o), .dq_oe(dq_oe)
   );

   int n_cmp = 0;
   int n_bad = 0;
   string tag = "R9";

   // reference model state
   bit            m_act = 0;
   int            m_up = 0, m_base = 0, m_cnt = 0;
   bit            m_rvld = 0, m_known = 0;
   logic [DW-1:0] m_rdat = '0;
   logic [DW-1:0] m_mem [int];

   function automatic logic [DW-1:0] pat(input int a);
      return {9'(a * 7 + 1), 9'(a * 3 + 2), 9'(a + 100), 9'(a * 5 + 4)};
   endfunction

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   task automatic model_edge();
      bit ok;
      bit [3:0] ln;
      int kind, a, lo;
      ok = !sel_pri_n && sel_sec_p && !sel_sec_n;
      if (!gwr_n)      ln = 4'hF;
      else if (!bwr_n) ln = ~lane_we_n;
      else             ln = 4'h0;
      kind = 0;
      if (rst) begin
         m_act = 0; m_cnt = 0;
      end else if (!sel_pri_n && !stb_proc_n) begin
         if (ok) begin
            m_act = 1; m_up = int'(addr) / 4; m_base = int'(addr) % 4; m_cnt = 0; kind = 1;
         end else m_act = 0;
      end else if (!stb_ctl_n) begin
         if (ok) begin
            m_act = 1; m_up = int'(addr) / 4; m_base = int'(addr) % 4; m_cnt = 0;
            kind = (ln != 0) ? 2 : 1;
         end else m_act = 0;
      end else if (m_act) begin
         if (!adv_n) m_cnt = (m_cnt + 1) % 4;
         kind = (ln != 0) ? 2 : 1;
      end
      lo = intlv ? (m_base ^ m_cnt) : ((m_base + m_cnt) % 4);
      a  = m_up * 4 + lo;
      if (kind == 2) begin
         logic [DW-1:0] w;
         w = m_mem.exists(a) ? m_mem[a] : '0;
         for (int i = 0; i < 4; i++) if (ln[i]) w[i*9 +: 9] = wdata[i*9 +: 9];
         m_mem[a] = w;
      end
      m_rvld = (kind == 1);
      if (kind == 1) begin
         m_known = m_mem.exists(a);
         if (m_known) m_rdat = m_mem[a];
      end
   endtask

   task automatic model_check();
      bit e_oe;
      e_oe = m_rvld && !oe_n;
      n_cmp++;
      if (dq_oe !== e_oe) begin
         n_bad++;
         $display("FAIL %s model dq_oe actual=%b expected=%b", tag, dq_oe, e_oe);
      end else if (e_oe && m_known) begin
         n_cmp++;
         if (dq_o !== m_rdat) begin
            n_bad++;
            $display("FAIL %s model dq_o actual=%h expected=%h", tag, dq_o, m_rdat);
         end
      end
   endtask

   task automatic tick();
      @(posedge clk);
      model_edge();
      @(negedge clk);
      model_check();
   endtask

   task automatic exp_data(input logic [DW-1:0] e, input string t);
      n_cmp++;
      if (dq_oe !== 1'b1 || dq_o !== e) begin
         n_bad++;
         $display("FAIL %s data actual=%h oe=%b expected=%h", t, dq_o, dq_oe, e);
      end
   endtask

   task automatic exp_quiet(input string t);
      n_cmp++;
      if (dq_oe !== 1'b0) begin
         n_bad++;
         $display("FAIL %s dq_oe actual=%b expected=0", t, dq_oe);
      end
   endtask

   task automatic idle();
      sel_pri_n = 1; sel_sec_p = 1; sel_sec_n = 0; stb_proc_n = 1; stb_ctl_n = 0;
      adv_n = 1; gwr_n = 1; bwr_n = 1; lane_we_n = 4'hF;
   endtask

   task automatic start(input bit proc, input int a);
      sel_pri_n = 0; sel_sec_p = 1; sel_sec_n = 0;
      stb_proc_n = !proc; stb_ctl_n = proc; addr = AW'(a);
   endtask

   task automatic burst(input bit adv);
      stb_proc_n = 1; stb_ctl_n = 1; adv_n = !adv;
   endtask

   initial begin
      #(4 * 100000);
      n_bad++;
      $display("FAIL R9 watchdog expired");
      summary();
   end

   initial begin
      logic [DW-1:0] ones, mix;
      ones = '1;
      idle(); intlv = 0; oe_n = 0; addr = '0; wdata = '0; rst = 1;
      @(negedge clk);
      tick(); tick();
      exp_quiet("R9");
      rst = 0;
      tag = "R4";
      // fill addresses 0..15 with controller-strobe global writes
      for (int a = 0; a < 16; a++) begin
         start(0, a); gwr_n = 0; wdata = pat(a);
         tick();
         exp_quiet("R8");
      end
      // R3: processor start with write asserted still reads
      tag = "R3";
      start(1, 5); gwr_n = 0; wdata = '0;
      tick(); exp_data(pat(5), "R3");
      // R7 linear order 5,6,7,4 via advance
      tag = "R7"; gwr_n = 1;
      burst(1); tick(); exp_data(pat(6), "R7");
      tick(); exp_data(pat(7), "R7");
      tick(); exp_data(pat(4), "R7");
      // R5 hold keeps the address
      tag = "R5";
      burst(0); tick(); exp_data(pat(4), "R5");
      // R5 primary high blocks the processor strobe: a step, selects ignored
      sel_pri_n = 1; sel_sec_p = 0; stb_proc_n = 0; stb_ctl_n = 1; adv_n = 0; addr = 10'd40;
      tick(); exp_data(pat(5), "R5");
      // R7 interleaved from 9: 9,8,11,10
      tag = "R7"; intlv = 1;
      start(1, 9); tick(); exp_data(pat(9), "R7");
      burst(1); tick(); exp_data(pat(8), "R7");
      tick(); exp_data(pat(11), "R7");
      tick(); exp_data(pat(10), "R7");
      intlv = 0;
      // R6 masked write of lanes 0 and 2 at 12
      tag = "R6";
      start(0, 12); gwr_n = 1; bwr_n = 0; lane_we_n = 4'b1010; wdata = ones;
      tick(); exp_quiet("R6");
      bwr_n = 1; lane_we_n = 4'hF;
      start(1, 12); tick();
      mix = pat(12); mix[8:0] = 9'h1FF; mix[26:18] = 9'h1FF;
      exp_data(mix, "R6");
      // R6 byte-write with no lane enabled reads
      start(0, 13); bwr_n = 0; lane_we_n = 4'hF; wdata = ones;
      tick(); exp_data(pat(13), "R6");
      // R6 global write overrides mask
      start(0, 14); gwr_n = 0; bwr_n = 0; lane_we_n = 4'b1110; wdata = ones;
      tick(); exp_quiet("R6");
      gwr_n = 1; bwr_n = 1; lane_we_n = 4'hF;
      start(1, 14); tick(); exp_data(ones, "R6");
      // R1 deselect then R9 step while idle
      tag = "R1";
      sel_pri_n = 1; stb_ctl_n = 0; stb_proc_n = 0;
      tick(); exp_quiet("R1");
      tag = "R9";
      burst(1); tick(); exp_quiet("R9");
      burst(0); tick(); exp_quiet("R9");
      // R2 secondary selects inactive
      tag = "R2";
      start(1, 2); sel_sec_p = 0; tick(); exp_quiet("R2");
      start(0, 2); sel_sec_n = 1; tick(); exp_quiet("R2");
      burst(1); tick(); exp_quiet("R2");
      // R4/R5 write burst: 3 then linear step to 0
      tag = "R4";
      start(0, 3); gwr_n = 0; wdata = 36'h123456789; tick();
      burst(1); wdata = 36'hABCDEF012; tick();
      gwr_n = 1;
      start(1, 3); tick(); exp_data(36'h123456789, "R4");
      burst(1); tick(); exp_data(36'hABCDEF012, "R5");
      // R8 output enable gating
      tag = "R8";
      start(1, 1); oe_n = 1; tick(); exp_quiet("R8");
      oe_n = 0; #0.5; exp_data(pat(1), "R8");
      burst(0); tick(); exp_data(pat(1), "R8");
      // random phase over addresses 0..15
      tag = "R5";
      for (int i = 0; i < 400; i++) begin
         sel_pri_n = 1'($urandom_range(0, 3) == 0);
         sel_sec_p = 1'($urandom_range(0, 5) != 0);
         sel_sec_n = 1'($urandom_range(0, 5) == 0);
         stb_proc_n = 1'($urandom_range(0, 3) != 0);
         stb_ctl_n = 1'($urandom_range(0, 2) != 0);
         adv_n = 1'($urandom);
         gwr_n = 1'($urandom_range(0, 4) != 0);
         bwr_n = 1'($urandom);
         lane_we_n = 4'($urandom);
         intlv = 1'($urandom);
         oe_n = 1'($urandom_range(0, 4) == 0);
         addr = AW'($urandom_range(0, 15));
         wdata = {4'($urandom), 32'($urandom)};
         tick();
      end
      summary();
   end
endmodule